// File: doc/BRIEF.md
# Packed Indexed Pixel Unpacker

This block sits between a frame-buffer byte stream and a display pipeline that works on color indices. Each incoming byte holds one, two, four or eight pixel indices, depending on the run-time color depth. The block emits them one per cycle as an 8-bit index with the unused upper bits cleared. A run-time order control chooses whether the leftmost pixel on screen comes from the top or the bottom bit group of each byte.

Both sides use a valid/ready handshake. A byte is held until every pixel cut from it has been accepted downstream. The next byte is accepted in the same cycle as the last pixel of the current byte, so an unstalled stream yields one pixel every cycle. Depth and order are captured together with each byte, so a change while a byte is being unpacked only affects later bytes.

Top module: `pix_unpack`

## Requirements
- R1: The depth input `depth_sel` selects the pixel size: 2'b00 gives 1 bit (8 pixels per byte), 2'b01 gives 2 bits (4 per byte), 2'b10 gives 4 bits (2 per byte) and 2'b11 gives 8 bits (1 per byte). Exactly that many pixels are emitted for every accepted byte.
- R2: With `msb_first` = 1, the first pixel of a byte comes from the top group (bit 7, bits 7:6 or bits 7:4), and each later pixel comes from the next lower group.
- R3: With `msb_first` = 0, the first pixel comes from the bottom group (bit 0, bits 1:0 or bits 3:0), and each later pixel comes from the next higher group.
- R4: Within a multi-bit pixel, the highest-numbered bit of its group is the most significant bit of the index, whatever the order setting.
- R5: Every pixel of one byte is emitted before any pixel of the next accepted byte. `px_valid` is high exactly while pixels of an accepted byte remain to be delivered.
- R6: At 8 bits per pixel the index equals the whole byte, whatever the order setting.
- R7: Index bits at and above the pixel size are zero.
- R8: `in_ready` is high when no byte is held, or when the last pixel of the held byte is being accepted in that cycle, and is low otherwise. An unstalled stream of bytes therefore gives one pixel per cycle with no gaps.
- R9: While `px_valid` is high and `px_ready` is low, `px_idx` and `px_valid` hold their values.
- R10: `depth_sel` and `msb_first` are sampled only in the cycle a byte is accepted. Changing them while a byte is being unpacked does not affect that byte.
- R11: A synchronous active-high reset `rst` clears `px_valid` and the pixel position, so the next accepted byte starts from its first pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 8 | Packed frame-buffer byte |
| in_valid | input | 1 | Byte available |
| in_ready | output | 1 | Byte accepted when high together with in_valid |
| depth_sel | input | 2 | Pixel size code, sampled when a byte is accepted |
| msb_first | input | 1 | 1: first pixel from the top group; 0: from the bottom group |
| px_idx | output | IDX_W (8) | Zero-extended pixel index |
| px_valid | output | 1 | Pixel index available |
| px_ready | input | 1 | Downstream accepts the pixel |

## Verification
On every cycle, the checker enforces these rules: a stalled pixel is held steady, unused index bits are zero, the captured configuration stays frozen while a byte is in flight, an 8-bit pixel equals the held byte, and the output drops after the final pixel when no byte follows. Whether each pixel comes from the right bit group, in the right order, with the right bit significance, can only be shown by the bench comparing against its own per-bit model across depths and orders. The same holds for the gap-free throughput of a back-to-back burst and for the restart at the first pixel after a reset in the middle of a byte.

// File: rtl/pix_unpack_pkg.sv
package pix_unpack_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    DEPTH_1 = 2'b00,
    DEPTH_2 = 2'b01,
    DEPTH_4 = 2'b10,
    DEPTH_8 = 2'b11
  } depth_e;

  // bits per pixel: 1 << code
  function automatic logic [3:0] bits_per_px(input depth_e d);
    return 4'd1 << d;
  endfunction

  // index of the final pixel slot within one byte
  function automatic logic [2:0] last_slot(input depth_e d);
    case (d)
      DEPTH_1: return 3'd7;
      DEPTH_2: return 3'd3;
      DEPTH_4: return 3'd1;
      default: return 3'd0;
    endcase
  endfunction

  // pick the index for a given slot; bit significance inside a group is fixed
  function automatic logic [BYTE_W-1:0] pick(input logic [BYTE_W-1:0] b,
                                             input depth_e d,
                                             input logic msb,
                                             input logic [2:0] slot);
    logic [2:0] grp;
    logic [2:0] shift;
    logic [BYTE_W-1:0] mask;
    grp   = msb ? (last_slot(d) - slot) : slot;
    shift = grp << d;
    mask  = 8'hFF >> (4'd8 - bits_per_px(d));
    return (b >> shift) & mask;
  endfunction
endpackage

// File: rtl/pix_unpack_ctrl.sv
module pix_unpack_ctrl
  import pix_unpack_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        depth_sel,
  input  logic              msb_first,
  input  logic              px_ready,
  output logic              px_valid,
  output logic [BYTE_W-1:0] byte_q,
  output depth_e            depth_q,
  output logic              msb_q,
  output logic [2:0]        slot_q,
  output logic              last_w,
  output logic              fire_w,
  output logic              take_w
);
  logic full_q;

  assign last_w   = (slot_q == last_slot(depth_q));
  assign fire_w   = full_q && px_ready;
  assign in_ready = !full_q || (fire_w && last_w);
  assign take_w   = in_valid && in_ready;
  assign px_valid = full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q  <= 1'b0;
      slot_q  <= 3'd0;
      byte_q  <= '0;
      depth_q <= DEPTH_1;
      msb_q   <= 1'b0;
    end else if (take_w) begin
      full_q  <= 1'b1;
      slot_q  <= 3'd0;
      byte_q  <= in_data;
      depth_q <= depth_e'(depth_sel);
      msb_q   <= msb_first;
    end else if (fire_w) begin
      if (last_w) begin
        full_q <= 1'b0;
        slot_q <= 3'd0;
      end else begin
        slot_q <= slot_q + 3'd1;
      end
    end
  end
endmodule

// File: rtl/pix_unpack_extract.sv
module pix_unpack_extract
  import pix_unpack_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic [BYTE_W-1:0] byte_q,
  input  depth_e            depth_q,
  input  logic              msb_q,
  input  logic [2:0]        slot_q,
  output logic [IDX_W-1:0]  px_idx
);
  localparam int PAD_W = (IDX_W > BYTE_W) ? IDX_W - BYTE_W : 1;

  logic [BYTE_W-1:0] idx8;
  assign idx8 = pick(byte_q, depth_q, msb_q, slot_q);

  generate
    if (IDX_W > BYTE_W) begin : g_wide
      assign px_idx = {{PAD_W{1'b0}}, idx8};
    end else begin : g_exact
      assign px_idx = idx8;
    end
  endgenerate
endmodule

// File: rtl/pix_unpack.sv
module pix_unpack
  import pix_unpack_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       depth_sel,
  input  logic             msb_first,
  output logic [IDX_W-1:0] px_idx,
  output logic             px_valid,
  input  logic             px_ready
);
  logic [BYTE_W-1:0] byte_q;
  depth_e            depth_q;
  logic              msb_q;
  logic [2:0]        slot_q;
  logic              last_w;
  logic              fire_w;
  logic              take_w;

  pix_unpack_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .depth_sel (depth_sel),
    .msb_first (msb_first),
    .px_ready  (px_ready),
    .px_valid  (px_valid),
    .byte_q    (byte_q),
    .depth_q   (depth_q),
    .msb_q     (msb_q),
    .slot_q    (slot_q),
    .last_w    (last_w),
    .fire_w    (fire_w),
    .take_w    (take_w)
  );

  pix_unpack_extract #(.IDX_W(IDX_W)) u_extract (
    .byte_q  (byte_q),
    .depth_q (depth_q),
    .msb_q   (msb_q),
    .slot_q  (slot_q),
    .px_idx  (px_idx)
  );
endmodule

// File: rtl/pix_unpack_chk.sv
module pix_unpack_chk
  import pix_unpack_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              px_valid,
  input logic              px_ready,
  input logic [IDX_W-1:0]  px_idx,
  input logic [BYTE_W-1:0] byte_q,
  input depth_e            depth_q,
  input logic              msb_q,
  input logic              last_w,
  input logic              fire_w,
  input logic              take_w
);
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (px_valid && !px_ready) |=> (px_valid && $stable(px_idx)));

  assert_zero_ext_R7: assert property (@(posedge clk) disable iff (rst)
    px_valid |-> ((px_idx >> bits_per_px(depth_q)) == '0));

  assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    (px_valid && !take_w) |=> ($stable(depth_q) && $stable(msb_q) && $stable(byte_q)));

  assert_full_byte_R6: assert property (@(posedge clk) disable iff (rst)
    (px_valid && depth_q == DEPTH_8) |-> (px_idx == IDX_W'(byte_q)));

  assert_drain_R8: assert property (@(posedge clk) disable iff (rst)
    (fire_w && last_w && !take_w) |=> !px_valid);

  assert_take_R5: assert property (@(posedge clk) disable iff (rst)
    take_w |=> px_valid);

  assert_reset_R11: assert property (@(posedge clk)
    rst |=> !px_valid);
endmodule

bind pix_unpack pix_unpack_chk #(.IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .px_valid (px_valid),
  .px_ready (px_ready),
  .px_idx   (px_idx),
  .byte_q   (byte_q),
  .depth_q  (depth_q),
  .msb_q    (msb_q),
  .last_w   (last_w),
  .fire_w   (fire_w),
  .take_w   (take_w)
);

// File: tb/pix_unpack_tb.sv
`timescale 1ns/1ps
module pix_unpack_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [1:0] depth_sel = '0;
  logic       msb_first = 1'b0;
  logic [7:0] px_idx;
  logic       px_valid;
  logic       px_ready = 1'b0;

  always #4 clk = ~clk;

  pix_unpack u_dut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .depth_sel(depth_sel), .msb_first(msb_first),
    .px_idx(px_idx), .px_valid(px_valid), .px_ready(px_ready)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [7:0] exp_q[$];
  logic [1:0] expd_q[$];
  logic [7:0] snd_b[$];
  logic [1:0] snd_d[$];
  logic       snd_m[$];

  bit         pend = 0;
  logic [7:0] pb;
  logic [1:0] pd;
  logic       pm;

  // per-bit model: group position from order, bits gathered top down
  function automatic logic [7:0] model_px(logic [7:0] b, logic [1:0] d, logic m, int k);
    int bpp = 1 << d;
    int n   = 8 / bpp;
    int grp = m ? (n - 1 - k) : k;
    logic [7:0] r = '0;
    for (int j = bpp - 1; j >= 0; j--) r = {r[6:0], b[grp * bpp + j]};
    return r;
  endfunction

  function automatic string tag_of(logic [1:0] d, logic m);
    if (d == 2'b11) return "R6 R10";
    return m ? "R2 R4 R10" : "R3 R4 R10";
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic queue_byte(logic [7:0] b, logic [1:0] d, logic m);
    snd_b.push_back(b); snd_d.push_back(d); snd_m.push_back(m);
  endtask

  task automatic cycle(int rdy_pct, int gap_pct);
    @(negedge clk);
    if (!pend && snd_b.size() > 0 && ($urandom % 100) >= gap_pct) begin
      pb = snd_b.pop_front(); pd = snd_d.pop_front(); pm = snd_m.pop_front();
      pend = 1;
    end
    in_valid  = pend;
    in_data   = pend ? pb : 8'($urandom);
    depth_sel = pend ? pd : 2'($urandom);
    msb_first = pend ? pm : 1'($urandom);
    px_ready  = (($urandom % 100) < rdy_pct);
    #1;
    chk("R1 R8 in_ready", {7'd0, in_ready},
        {7'd0, (exp_q.size() == 0) || (px_ready && exp_q.size() == 1)});
    chk("R5 px_valid", {7'd0, px_valid}, {7'd0, exp_q.size() != 0});
    if (px_valid && exp_q.size() > 0) begin
      chk(px_ready ? tag_of(expd_q[0], 1'b0) : "R9 stall", px_idx, exp_q[0]);
      if (expd_q[0] != 2'b11)
        chk("R7 upper bits", px_idx >> (1 << expd_q[0]), 8'd0);
      if (px_ready) begin
        void'(exp_q.pop_front()); void'(expd_q.pop_front());
      end
    end
    if (in_valid && in_ready) begin
      for (int k = 0; k < 8 / (1 << pd); k++) begin
        exp_q.push_back(model_px(pb, pd, pm, k));
        expd_q.push_back(pd);
      end
      pend = 0;
    end
  endtask

  task automatic drain(int rdy_pct, int gap_pct);
    for (int i = 0; i < 20000 && (pend || snd_b.size() > 0 || exp_q.size() > 0); i++)
      cycle(rdy_pct, gap_pct);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    int total;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R11 reset px_valid", {7'd0, px_valid}, 8'd0);
    chk("R11 reset in_ready", {7'd0, in_ready}, 8'd1);

    // directed: one pattern across every depth and order (R1 R2 R3 R4 R6)
    for (int d = 0; d < 4; d++)
      for (int m = 0; m < 2; m++) queue_byte(8'hB4, 2'(d), 1'(m));
    queue_byte(8'h01, 2'b00, 1'b1);
    queue_byte(8'h80, 2'b00, 1'b0);
    queue_byte(8'hC3, 2'b01, 1'b1);
    drain(100, 0);
    chk("R2 R4 direct 2bpp top", model_px(8'hB4, 2'b01, 1'b1, 0), 8'h2);
    chk("R3 R4 direct 4bpp bottom", model_px(8'hB4, 2'b10, 1'b0, 0), 8'h4);

    // back-to-back burst, no stalls: gap-free output (R8)
    repeat (2) cycle(100, 100);
    total = 0;
    for (int i = 0; i < 20; i++) begin
      logic [1:0] d = 2'($urandom);
      queue_byte(8'($urandom), d, 1'($urandom));
      total += 8 / (1 << d);
    end
    repeat (total + 1) cycle(100, 0);
    chk("R8 no bubbles", 8'(exp_q.size() + snd_b.size() + int'(pend)), 8'd0);

    // reset in the middle of a byte (R11)
    queue_byte(8'hA5, 2'b00, 1'b1);
    repeat (3) cycle(100, 0);
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    exp_q.delete(); expd_q.delete(); pend = 0;
    #1;
    chk("R11 mid-byte reset px_valid", {7'd0, px_valid}, 8'd0);
    queue_byte(8'h5A, 2'b00, 1'b1);
    drain(100, 0);

    // random traffic with stalls and config churn (R5 R9 R10)
    for (int i = 0; i < 400; i++)
      queue_byte(8'($urandom), 2'($urandom), 1'($urandom));
    drain(70, 30);
    repeat (4) cycle(50, 100);
    finish_run();
  end
endmodule